// File: doc/BRIEF.md
# Interrupt Distributor Security Control Register

This block holds the top-level control register of an interrupt distributor and a read-only type register beside it. Software reaches both over a small memory-mapped register bus. Every access is tagged as secure or non-secure. The block drives the group enables, the affinity-routing enable and a flag that tells the rest of the distributor whether it runs with a single security state.

A build-time parameter picks one of two security models. In the single-state build, both interrupt groups are open to every caller, and the disable-security flag is fixed at 1. In the two-state build, the flag starts at 0. Only a secure write can set it. Once set, it stays set until reset. While it is 0, the group 0 enable belongs to the secure side alone.

A write that changes any enable bit raises a write-pending flag. The flag stays up for a parameterised number of cycles, so software can poll until the change has settled.

Top module: `irqd_ctl_bank`

## Requirements
- R1: After reset, every enable bit, the affinity-routing bit and the stored disable-security flag are 0. The single-security output is 0 in the two-state build and 1 in the single-state build.
- R2: The bus is always ready. A read accepted at a clock edge returns its data, with the response valid set for exactly one cycle, in the cycle after that edge. Writes give no response. The read data reflects the register state before the accepting edge.
- R3: The control register sits at word 0. Its fields are: bit 0 group 1 enable, bit 1 group 1A enable, bit 2 group 0 enable, bit 4 affinity-routing enable, bit 6 disable-security flag, bit 31 write pending (read-only). Every other bit reads 0 and ignores writes.
- R4: The type register sits at word 1. Bit 10 reads 1 exactly when the block is built with two security states. All its other bits read 0, and writes to it have no effect.
- R5: Any other word address reads 0, and a write to it changes no state.
- R6: In the single-state build, bit 6 reads 1 for both secure and non-secure accesses, writes to it have no effect, and the single-security output is 1.
- R7: In the two-state build, a non-secure read returns bit 6 as 0, and a non-secure write never changes the stored flag.
- R8: In the two-state build, a secure write with bit 6 = 1 sets the flag. A later secure write with bit 6 = 0 leaves it set. Only reset clears it. The single-security output equals the stored flag.
- R9: A secure access always reads and writes the group 0 enable. A non-secure access reaches it only while the effective disable-security flag is 1. Otherwise a non-secure read sees bit 2 as 0 and a non-secure write leaves it unchanged.
- R10: A control write that changes bit 0, 1 or 2 makes bit 31 read 1 for reads presented in the next PEND_CYCLES cycles, then 0. A write that changes no enable bit leaves the pending timer alone.
- R11: The enable and affinity-routing outputs take the new register value in the cycle after the accepting write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Always 1: every request is taken in its cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access, 0 = non-secure |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| grp0_en_o | output | 1 | Group 0 enable |
| grp1_en_o | output | 1 | Group 1 enable |
| grp1a_en_o | output | 1 | Group 1A enable |
| are_ns_o | output | 1 | Affinity routing enable, non-secure view |
| single_sec_o | output | 1 | Effective single-security-state flag |

## Verification
Stickiness gets the most attention. The bench clears the flag with a secure 0 after setting it, and then resets the block in mid-run. A design that let a write clear the flag would drop the single-security output, and one that ignored reset would keep it high afterwards. Non-secure writes of all ones hit the flag and the group 0 enable while the flag is 0. A leaky design would set group 0, or report single-security mode, too early. The pending bit is polled on every cycle of its window, both after a real change and after a rewrite of the same value, so an off-by-one timer or a timer that fires on any write shows up directly. The bench also sends reads and writes to unmapped addresses and to the type register, to catch decode aliasing.

// File: rtl/irqd_ctl_pkg.sv
package irqd_ctl_pkg;

  localparam int DATA_W       = 32;
  localparam int BIT_G1       = 0;
  localparam int BIT_G1A      = 1;
  localparam int BIT_G0       = 2;
  localparam int BIT_ARE      = 4;
  localparam int BIT_DS       = 6;
  localparam int BIT_SEC_IMPL = 10;
  localparam int BIT_PEND     = 31;

  typedef struct packed {
    logic pend;
    logic ds;
    logic are;
    logic g0;
    logic g1a;
    logic g1;
  } ctl_view_t;

  // Assemble the control word seen by a reader
  function automatic logic [DATA_W-1:0] pack_ctl(input ctl_view_t v);
    logic [DATA_W-1:0] w;
    w               = '0;
    w[BIT_G1]       = v.g1;
    w[BIT_G1A]      = v.g1a;
    w[BIT_G0]       = v.g0;
    w[BIT_ARE]      = v.are;
    w[BIT_DS]       = v.ds;
    w[BIT_PEND]     = v.pend;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_type(input logic two_states);
    logic [DATA_W-1:0] w;
    w               = '0;
    w[BIT_SEC_IMPL] = two_states;
    return w;
  endfunction

  // Value of the disable-security bit as returned to a given caller
  function automatic logic ds_visible(input logic two_states, input logic secure,
                                      input logic ds_q);
    if (!two_states) return 1'b1;
    return secure & ds_q;
  endfunction

  // Whether the caller may touch the group 0 enable
  function automatic logic grp0_reachable(input logic secure, input logic eff_ds);
    return secure | eff_ds;
  endfunction

endpackage

// File: rtl/irqd_ctl_decode.sv
module irqd_ctl_decode #(
  parameter int ADDR_W   = 10,
  parameter int CTRL_IDX = 0,
  parameter int TYPE_IDX = 1
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ctrl_wr,
  output logic              ctrl_rd,
  output logic              type_rd,
  output logic              any_rd
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] TYPE_A = ADDR_W'(TYPE_IDX);

  logic hit_ctrl, hit_type;

  always_comb begin
    hit_ctrl = (req_addr == CTRL_A);
    hit_type = (req_addr == TYPE_A);
    ctrl_wr  = req_valid &  req_write & hit_ctrl;
    ctrl_rd  = req_valid & ~req_write & hit_ctrl;
    type_rd  = req_valid & ~req_write & hit_type;
    any_rd   = req_valid & ~req_write;
  end
endmodule

// File: rtl/irqd_ctl_secflag.sv
module irqd_ctl_secflag #(
  parameter bit TWO_STATES = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_wr,
  input  logic wr_bit,
  output logic ds_q,
  output logic eff_ds
);
  generate
    if (TWO_STATES) begin : g_banked
      logic ds_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ds_r <= 1'b0;
        else if (sec_wr && wr_bit) ds_r <= 1'b1;
      end
      assign ds_q   = ds_r;
      assign eff_ds = ds_r;

      // Once set, the flag holds until reset
      assert_ds_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ds_r) |-> ds_r);
      assert_ds_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_wr && wr_bit) |=> ds_r);
    end else begin : g_fixed
      assign ds_q   = 1'b1;
      assign eff_ds = 1'b1;
      logic fixed_unused;
      assign fixed_unused = clk ^ rst_n ^ sec_wr ^ wr_bit;
    end
  endgenerate
endmodule

// File: rtl/irqd_ctl_pend.sv
module irqd_ctl_pend #(
  parameter int PEND_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic pend
);
  localparam int CW = $clog2(PEND_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (trigger)        cnt_q <= CW'(PEND_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pend = (cnt_q != '0);

  assert_pend_after_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> pend);
endmodule

// File: rtl/irqd_ctl_bank.sv
module irqd_ctl_bank
  import irqd_ctl_pkg::*;
#(
  parameter bit TWO_STATES  = 1'b1,
  parameter int ADDR_W      = 10,
  parameter int PEND_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              grp0_en_o,
  output logic              grp1_en_o,
  output logic              grp1a_en_o,
  output logic              are_ns_o,
  output logic              single_sec_o
);
  logic ctrl_wr, ctrl_rd, type_rd, any_rd;
  logic ds_q, eff_ds, pend;
  logic g0_q, g1_q, g1a_q, are_q;
  logic g0_reach, enable_change;
  logic [31:0] rd_word;
  ctl_view_t view;
  logic wdata_unused;

  assign req_ready    = 1'b1;
  assign wdata_unused = ^req_wdata;

  irqd_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .type_rd(type_rd), .any_rd(any_rd)
  );

  irqd_ctl_secflag #(.TWO_STATES(TWO_STATES)) u_sec (
    .clk(clk), .rst_n(rst_n),
    .sec_wr(ctrl_wr & req_secure), .wr_bit(req_wdata[BIT_DS]),
    .ds_q(ds_q), .eff_ds(eff_ds)
  );

  assign g0_reach      = grp0_reachable(req_secure, eff_ds);
  assign enable_change = ctrl_wr &&
                         ((g1_q  != req_wdata[BIT_G1]) ||
                          (g1a_q != req_wdata[BIT_G1A]) ||
                          (g0_reach && (g0_q != req_wdata[BIT_G0])));

  irqd_ctl_pend #(.PEND_CYCLES(PEND_CYCLES)) u_pend (
    .clk(clk), .rst_n(rst_n), .trigger(enable_change), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g0_q  <= 1'b0;
      g1_q  <= 1'b0;
      g1a_q <= 1'b0;
      are_q <= 1'b0;
    end else if (ctrl_wr) begin
      g1_q  <= req_wdata[BIT_G1];
      g1a_q <= req_wdata[BIT_G1A];
      are_q <= req_wdata[BIT_ARE];
      if (g0_reach) g0_q <= req_wdata[BIT_G0];
    end
  end

  always_comb begin
    view.pend = pend;
    view.ds   = ds_visible(TWO_STATES, req_secure, ds_q);
    view.are  = are_q;
    view.g0   = g0_reach ? g0_q : 1'b0;
    view.g1a  = g1a_q;
    view.g1   = g1_q;
    if (ctrl_rd)      rd_word = pack_ctl(view);
    else if (type_rd) rd_word = pack_type(TWO_STATES);
    else              rd_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= any_rd;
      rsp_rdata <= rd_word;
    end
  end

  assign grp0_en_o    = g0_q;
  assign grp1_en_o    = g1_q;
  assign grp1a_en_o   = g1a_q;
  assign are_ns_o     = are_q;
  assign single_sec_o = eff_ds;

  assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_write_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);
  assert_type_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    type_rd |=> (rsp_rdata[BIT_SEC_IMPL] == TWO_STATES));
  assert_unmapped_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !ctrl_wr) |=>
      ($stable(g0_q) && $stable(g1_q) && $stable(g1a_q) && $stable(are_q) && $stable(ds_q)));
  assert_ns_ds_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !req_secure) |=> $stable(ds_q));
  assert_grp0_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !req_secure && !eff_ds) |=> $stable(g0_q));
  assert_outputs_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (grp1_en_o == $past(req_wdata[BIT_G1]) && are_ns_o == $past(req_wdata[BIT_ARE])));
endmodule

// File: tb/irqd_ctl_bank_test.sv
module irqd_ctl_bank_test;
  localparam int AW = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;

  logic rdy[2], rv[2], g0[2], g1[2], g1a[2], are[2], ss[2];
  logic [31:0] rd[2];

  always #5 clk = ~clk;

  irqd_ctl_bank #(.TWO_STATES(1'b1), .ADDR_W(AW), .PEND_CYCLES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rv[0]), .rsp_rdata(rd[0]),
    .grp0_en_o(g0[0]), .grp1_en_o(g1[0]), .grp1a_en_o(g1a[0]),
    .are_ns_o(are[0]), .single_sec_o(ss[0]));

  irqd_ctl_bank #(.TWO_STATES(1'b0), .ADDR_W(AW), .PEND_CYCLES(NP)) uut_single (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rv[1]), .rsp_rdata(rd[1]),
    .grp0_en_o(g0[1]), .grp1_en_o(g1[1]), .grp1a_en_o(g1a[1]),
    .are_ns_o(are[1]), .single_sec_o(ss[1]));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // Reference model: index 0 = two security states, index 1 = single state
  bit m_g0[2], m_g1[2], m_g1a[2], m_are[2], m_ds[2];
  int m_cnt[2];
  bit e_rv[2];
  logic [31:0] e_rd[2];

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      m_g0[m] = 0; m_g1[m] = 0; m_g1a[m] = 0; m_are[m] = 0;
      m_ds[m] = (m == 1); m_cnt[m] = 0; e_rv[m] = 0; e_rd[m] = 0;
    end
  endtask

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int m = 0; m < 2; m++) begin
      chk(m == 0 ? "two:ready R2" : "one:ready R2", {31'd0, rdy[m]}, 32'd1);
      chk(m == 0 ? "two:rsp_valid R2" : "one:rsp_valid R2", {31'd0, rv[m]}, {31'd0, e_rv[m]});
      if (e_rv[m]) chk(m == 0 ? "two:rdata" : "one:rdata", rd[m], e_rd[m]);
      chk(m == 0 ? "two:grp0 R11" : "one:grp0 R11", {31'd0, g0[m]}, {31'd0, m_g0[m]});
      chk(m == 0 ? "two:grp1 R11" : "one:grp1 R11", {31'd0, g1[m]}, {31'd0, m_g1[m]});
      chk(m == 0 ? "two:grp1a R11" : "one:grp1a R11", {31'd0, g1a[m]}, {31'd0, m_g1a[m]});
      chk(m == 0 ? "two:are R11" : "one:are R11", {31'd0, are[m]}, {31'd0, m_are[m]});
      chk(m == 0 ? "two:single_sec R8" : "one:single_sec R6", {31'd0, ss[m]}, {31'd0, m_ds[m]});
    end
  endtask

  task automatic model_step(input bit v, input bit w, input bit s, input int a,
                            input logic [31:0] d);
    for (int m = 0; m < 2; m++) begin
      bit reach;
      bit changed;
      reach = s || m_ds[m];
      e_rv[m] = v && !w;
      e_rd[m] = 0;
      if (v && !w) begin
        if (a == 0) begin
          e_rd[m][0]  = m_g1[m];
          e_rd[m][1]  = m_g1a[m];
          e_rd[m][2]  = reach ? m_g0[m] : 1'b0;
          e_rd[m][4]  = m_are[m];
          e_rd[m][6]  = (m == 1) ? 1'b1 : (s && m_ds[m]);
          e_rd[m][31] = (m_cnt[m] > 0);
        end else if (a == 1) begin
          e_rd[m][10] = (m == 0);
        end
      end
      if (m_cnt[m] > 0) m_cnt[m]--;
      if (v && w && a == 0) begin
        changed = (m_g1[m] != d[0]) || (m_g1a[m] != d[1]) || (reach && m_g0[m] != d[2]);
        if (changed) m_cnt[m] = NP;
        m_g1[m] = d[0]; m_g1a[m] = d[1]; m_are[m] = d[4];
        if (reach) m_g0[m] = d[2];
        if (m == 0 && s && d[6]) m_ds[m] = 1;
      end
    end
  endtask

  task automatic step(input bit v, input bit w, input bit s, input int a,
                      input logic [31:0] d);
    @(negedge clk);
    compare_all();
    req_valid = v; req_write = w; req_secure = s;
    req_addr = AW'(a); req_wdata = d;
    model_step(v, w, s, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 32'd0);
  endtask

  task automatic wr(input bit s, input int a, input logic [31:0] d);
    step(1, 1, s, a, d);
  endtask

  task automatic rdr(input bit s, input int a);
    step(1, 0, s, a, 32'd0);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    compare_all();
    req_valid = 0;
    rst_n = 0;
    model_reset();
    idle(2);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: state right after reset
    tag = "R1";
    idle(2);
    rdr(1, 0); rdr(0, 0);
    // R4: type register, and a write to it changes nothing
    tag = "R4";
    rdr(0, 1); rdr(1, 1); wr(1, 1, 32'hFFFF_FFFF); rdr(1, 0);
    // R3, R9, R7: non-secure write of all ones while the flag is 0
    tag = "R3 R9 R7";
    wr(0, 0, 32'hFFFF_FFFF);
    // R10: poll pending bit across the whole window and past it
    tag = "R10";
    for (int i = 0; i < NP + 2; i++) rdr(0, 0);
    tag = "R10 no-change";
    wr(0, 0, 32'hFFFF_FFFF);
    rdr(1, 0); rdr(1, 0);
    // R9: secure side owns group 0 while the flag is 0
    tag = "R9";
    wr(1, 0, 32'h0000_0017);
    rdr(0, 0); rdr(1, 0);
    wr(0, 0, 32'h0000_0003);
    rdr(1, 0);
    idle(NP);
    // R5: unmapped addresses
    tag = "R5";
    wr(1, 5, 32'hFFFF_FFFF); wr(0, 1023, 32'hFFFF_FFFF);
    rdr(1, 5); rdr(0, 2); rdr(1, 0);
    // R7: non-secure attempt to set the flag
    tag = "R7";
    wr(0, 0, 32'h0000_0040); rdr(0, 0); rdr(1, 0);
    // R8: secure set, then secure attempt to clear
    tag = "R8";
    wr(1, 0, 32'h0000_0040); rdr(1, 0); rdr(0, 0);
    wr(1, 0, 32'h0000_0000); rdr(1, 0);
    idle(NP);
    // R9: with the flag set, non-secure reaches group 0
    tag = "R9 ds=1";
    wr(0, 0, 32'h0000_0004); rdr(0, 0); rdr(1, 0);
    idle(NP);
    // R6: single build keeps the flag at 1 for every caller
    tag = "R6";
    wr(1, 0, 32'h0000_0000); wr(0, 0, 32'h0000_0000);
    rdr(0, 0); rdr(1, 0);
    // R11: back-to-back field patterns
    tag = "R11";
    wr(1, 0, 32'h0000_0012); wr(1, 0, 32'h0000_0001); wr(0, 0, 32'h0000_0016);
    idle(2);
    // R8: only reset clears the flag
    tag = "R8 reset";
    pulse_reset();
    tag = "R1 after reset";
    idle(1);
    rdr(1, 0); rdr(0, 0);
    idle(2);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule